// File: doc/BRIEF.md
# Round-Robin Differential BPSK Chip Spreader

This block turns a serial stream of data bits into a bipolar chip stream for a multipath-tolerant link. The block first passes each data bit through a differential encoder. The encoded bit then multiplies a five-chip spreading word. Three different spreading words are used in turn, one per symbol. Because the words rotate, echoes of one symbol fall on a word that is almost orthogonal to the next one.

A single chip-rate enable sets the timing. Every five enabled cycles make one symbol, and the block makes that division itself. Data enters through a valid/ready pair. The block raises ready only on the enabled cycle that sends the last chip of the current symbol. When no bit is valid at that moment, the block flags an underrun and encodes a logical zero, which is the value used for training runs.

The first symbol after reset carries the encoder's reference state and no data bit. Pulse shaping and carrier conversion are handled downstream.

Top module: `rr_dbpsk_spreader`

## Requirements
- R1: While reset is asserted and after it is released, the word index is 0, the chip position is the first chip, and the encoder state is 0. The first symbol therefore sends word 0 unmodified.
- R2: A word bit of 1 is sent as chip -1 and a bit of 0 as chip +1. The chips of a word are sent from its leftmost (most significant) bit to its rightmost.
- R3: Word 0 is 10110, word 1 is 10001 and word 2 is 11110. Successive symbols use words 0,1,2,0,... in order, and `codeIdx` shows the index of the word in use.
- R4: One symbol lasts exactly five enabled cycles. `symStart` is high only on the enabled cycle that sends the first chip of a symbol.
- R5: `bitReady` is high only on the enabled cycle that sends the fifth chip of a symbol. A bit presented with `bitValid` in that cycle is consumed, and it is never high in the same cycle as `symStart`.
- R6: The encoder state is updated as state = state XOR bit. When the state is 1, every chip of the following symbol is inverted; when it is 0, the chips follow R2.
- R7: If `bitValid` is low on a cycle where `bitReady` is high, `underrun` is high in that cycle. In that case the encoder state is left unchanged, exactly as for a zero bit.
- R8: On cycles with `chipEn` low, the chip position, the word index and the encoder state hold. The outputs `chipOut` and `codeIdx` do not change.
- R9: `chipOut` is a 2-bit signed value: +1 is 01 and -1 is 11. No other code appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chipEn | input | 1 | Chip-rate enable; one chip is sent per enabled cycle |
| bitValid | input | 1 | A data bit is offered |
| bitData | input | 1 | Data bit value |
| bitReady | output | 1 | Data bit is taken this cycle (last chip of the symbol) |
| chipOut | output | 2 | Current chip, signed: 01 = +1, 11 = -1 |
| symStart | output | 1 | First chip of a symbol is being sent |
| codeIdx | output | 2 | Index of the spreading word in use |
| underrun | output | 1 | No valid bit at the symbol boundary |

## Verification
Three events can land in one clock edge: the last chip of a symbol, the consumption of a data bit, and the step to the next word. The new encoder state and the new word index must both be visible on the very next chip. The bench varies the gaps in the enable pattern so that symbol boundaries fall with valid bits of both values and also during a stretch with no valid bit. For every sampled cycle it computes the chip from its own rotation and XOR model and compares it with the design's output.

// File: rtl/rr_spreader_pkg.sv
package rr_spreader_pkg;
  localparam int CHIP_LEN = 5;
  localparam int CODE_CNT = 3;
  localparam int CNT_W = $clog2(CHIP_LEN);
  localparam int IDX_W = $clog2(CODE_CNT);

  localparam logic [CHIP_LEN-1:0] CODE_TBL [CODE_CNT] = '{5'b10110, 5'b10001, 5'b11110};

  typedef struct packed {
    logic             tick;
    logic             symEnd;
    logic             takeBit;
    logic [IDX_W-1:0] codeSel;
    logic [CNT_W-1:0] chipPos;
  } ctrlStrobe_t;
endpackage

// File: rtl/rr_spreader_ctrl.sv
module rr_spreader_ctrl
  import rr_spreader_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chipEn,
  output ctrlStrobe_t stb
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(CHIP_LEN - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_CNT - 1);

  logic [CNT_W-1:0] chipCnt;
  logic [IDX_W-1:0] codeIdx;
  logic             atLast;

  assign atLast = (chipCnt == LAST_POS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chipCnt <= '0;
      codeIdx <= '0;
    end else if (chipEn) begin
      if (atLast) begin
        chipCnt <= '0;
        codeIdx <= (codeIdx == LAST_IDX) ? '0 : codeIdx + 1'b1;
      end else begin
        chipCnt <= chipCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb.tick    = chipEn;
    stb.symEnd  = chipEn & atLast;
    stb.takeBit = chipEn & atLast;
    stb.codeSel = codeIdx;
    stb.chipPos = chipCnt;
  end

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    chipCnt <= LAST_POS); // R4

  AST_ROTATE: assert property (@(posedge clk) disable iff (!rstN)
    stb.symEnd |=> (codeIdx == (($past(codeIdx) == LAST_IDX) ? '0 : $past(codeIdx) + 1'b1))); // R3

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |=> ($stable(chipCnt) && $stable(codeIdx))); // R8
endmodule

// File: rtl/rr_spreader_dp.sv
module rr_spreader_dp
  import rr_spreader_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic              bitValid,
  input  logic              bitData,
  output logic signed [1:0] chipOut
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(CHIP_LEN - 1);

  logic                encBit;
  logic [CODE_CNT-1:0] candBit;
  logic [CNT_W-1:0]    bitSel;
  logic                rawBit;

  assign bitSel = LAST_POS - stb.chipPos;

  for (genvar g = 0; g < CODE_CNT; g++) begin : gCand
    assign candBit[g] = CODE_TBL[g][bitSel];
  end

  always_comb begin
    rawBit = candBit[0];
    for (int i = 1; i < CODE_CNT; i++) begin
      if (stb.codeSel == IDX_W'(i)) rawBit = candBit[i];
    end
    chipOut = (rawBit ^ encBit) ? 2'sb11 : 2'sb01;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      encBit <= 1'b0;
    end else if (stb.takeBit && bitValid) begin
      encBit <= encBit ^ bitData;
    end
  end

  AST_CHIP_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (chipOut == 2'sb01) || (chipOut == 2'sb11)); // R9

  AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeBit && !bitValid) |=> (encBit == $past(encBit))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.tick |=> $stable(chipOut)); // R8
endmodule

// File: rtl/rr_dbpsk_spreader.sv
module rr_dbpsk_spreader
  import rr_spreader_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEn,
  input  logic              bitValid,
  input  logic              bitData,
  output logic              bitReady,
  output logic signed [1:0] chipOut,
  output logic              symStart,
  output logic [IDX_W-1:0]  codeIdx,
  output logic              underrun
);
  ctrlStrobe_t stb;

  rr_spreader_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .chipEn (chipEn),
    .stb    (stb)
  );

  rr_spreader_dp uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .bitValid (bitValid),
    .bitData  (bitData),
    .chipOut  (chipOut)
  );

  assign bitReady = stb.takeBit;
  assign symStart = stb.tick & (stb.chipPos == '0);
  assign codeIdx  = stb.codeSel;
  assign underrun = stb.takeBit & ~bitValid;

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({symStart, bitReady})); // R5

  AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> (bitReady && !bitValid)); // R7
endmodule

// File: tb/sim_rr_dbpsk_spreader.sv
module sim_rr_dbpsk_spreader;
  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              chipEn = 1'b0;
  logic              bitValid = 1'b0;
  logic              bitData = 1'b0;
  logic              bitReady;
  logic signed [1:0] chipOut;
  logic              symStart;
  logic [1:0]        codeIdx;
  logic              underrun;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int underrunSeen = 0;

  // model state
  int  mPos = 0;
  int  mIdx = 0;
  bit  mEnc = 1'b0;

  rr_dbpsk_spreader u0 (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .bitValid(bitValid), .bitData(bitData),
    .bitReady(bitReady), .chipOut(chipOut), .symStart(symStart), .codeIdx(codeIdx),
    .underrun(underrun)
  );

  always #2 clk = ~clk;

  function automatic logic [4:0] wordOf(int idx);
    case (idx)
      0: return 5'b10110;
      1: return 5'b10001;
      default: return 5'b11110;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    // R1: reset state while reset is held
    repeat (3) @(negedge clk);
    #1;
    chk("R1 codeIdx in reset", int'(codeIdx), 0);
    chk("R1 chip in reset", int'(chipOut), -1); // word 0 bit4 = 1 -> -1
    chk("R5 ready in reset", int'(bitReady), 0);
    chk("R4 symStart in reset", int'(symStart), 0);
    @(negedge clk);
    rstN = 1'b1;
    for (int cyc = 0; cyc < 1200; cyc++) begin
      @(negedge clk);
      chipEn   = (cyc < 600) ? ((cyc % 4) != 3) : ((cyc % 9) != 5);
      bitValid = !(cyc >= 300 && cyc < 380) && !(cyc >= 800 && cyc < 830);
      bitData  = cyc[1] ^ cyc[3] ^ cyc[6];
      #1;
      begin
        logic [4:0] w;
        bit cb;
        bit expEnd;
        w = wordOf(mIdx);
        cb = w[4 - mPos] ^ mEnc;
        expEnd = chipEn && (mPos == 4);
        chk("R2/R6/R9 chipOut", int'(chipOut), cb ? -1 : 1);
        chk("R3/R8 codeIdx", int'(codeIdx), mIdx);
        chk("R4 symStart", int'(symStart), int'(chipEn && mPos == 0));
        chk("R5 bitReady", int'(bitReady), int'(expEnd));
        chk("R7 underrun", int'(underrun), int'(expEnd && !bitValid));
        if (expEnd && !bitValid) underrunSeen++;
        if (chipEn) begin
          if (mPos == 4) begin
            if (bitValid) mEnc = mEnc ^ bitData;
            mIdx = (mIdx + 1) % 3;
            mPos = 0;
          end else begin
            mPos++;
          end
        end
      end
    end
    checks++;
    if (underrunSeen == 0) begin
      fails++;
      $display("FAIL R7: actual %0d underrun boundaries expected >0", underrunSeen);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule